// File: doc/BRIEF.md
# Eight-Bit Compare Timer

This block is an 8-bit counter with a small register window and two compare channels. A power-of-two prescaler sets how often the count moves. One of four counting modes decides its path: a plain rising count, a falling count that reloads, a count that wraps at a programmable ceiling, and a count that rises and then falls. The ceiling and the reload value both come from the compare value of channel 0.

Each channel compares the running count against its own value. On a match it drives its output pin through one of seven actions. Some actions only set, clear or toggle the pin. Others depend on whether the count is rising or falling, or also act when the count sits at its all-ones or all-zeros value. Matches and counter wraps set sticky flags, and each flag has its own enable onto a single interrupt line. Software uses the block by programming the channel values first and then writing the control register to start the count.

Top module: `tmr8_top`

## Requirements
- R1: Register map on `bus_addr`: 0 control, 1 count (read-only), 2 channel 0 control, 3 channel 0 value, 4 channel 1 control, 5 channel 1 value, 6 flags (bit 0 wrap, bit 1 channel 0 match, bit 2 channel 1 match). While reset is held and right after it, every register reads 0 and `cmp_out` and `irq` are 0.
- R2: Control bits 7:5 hold a code n. While running, the count moves once every 2^n clock cycles. The first move comes 2^n cycles after the write that starts the count.
- R3: Control bit 4 set lets the count move. Clearing it freezes the count at its current value, and setting it again resumes from that value.
- R4: Writing control with bit 2 set forces the count to 0 on the following cycle. Bit 2 then reads back as 0, and counting resumes from 0 if bit 4 is set.
- R5: Mode 0 (control bits 1:0 = 0) counts up and rolls from 0xFF to 0x00, setting flag bit 0 on the roll.
- R6: Mode 1 counts down. When the count is 0, the next move loads the channel 0 value and sets flag bit 0.
- R7: Mode 2 counts up. From a count equal to the channel 0 value the next move goes to 0 and sets flag bit 0.
- R8: Mode 3 counts up until it equals the channel 0 value and then counts down to 0. Leaving 0 on the way back up sets flag bit 0.
- R9: A match is a count move made while the count equals the channel value. The pin changes on that same edge. Action codes in channel control bits 5:3: 0 sets the pin, 1 clears it, 2 toggles it.
- R10: Action 3 drives the pin high on a match while counting up and low while counting down. Action 4 does the opposite. Mode 1 always counts down.
- R11: Action 5 sets the pin on a match and clears it on a move away from 0xFF. Action 6 clears it on a match and sets it on a move away from 0x00. When both events happen on one move, the match wins.
- R12: With channel control bit 2 clear, the channel neither changes its pin nor raises its flag.
- R13: Flags are set by hardware and stay set. A flags write keeps each bit written as 1 and clears each bit written as 0. `irq` is high while any flag is set whose enable is set: control bit 3 for the wrap flag, channel control bit 6 for a match flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released inside on the clock |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| cmp_out | output | 2 | Compare output pins, one per channel |
| irq | output | 1 | Interrupt request |

## Verification
A wrong count value or a wrong direction shows on the count register on the very next move, and also through the compare pins. Any action that depends on direction makes the wrong level visible at the next match. A prescaler fault shows up as a count that is off after exactly 2^n cycles. A wrong flag update shows on the flags register and on `irq` in the cycle after the event. The directed tests read these ports at the exact cycle each move is due, so a one-edge slip is caught.

// File: rtl/tmr8_pkg.sv
`timescale 1ns/1ps
package tmr8_pkg;

  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_DOWN = 2'd1,
    MODE_MOD  = 2'd2,
    MODE_UPDN = 2'd3
  } cnt_mode_e;

  typedef enum logic [2:0] {
    ACT_SET     = 3'd0,
    ACT_CLR     = 3'd1,
    ACT_TGL     = 3'd2,
    ACT_UP_SET  = 3'd3,
    ACT_UP_CLR  = 3'd4,
    ACT_SET_TOP = 3'd5,
    ACT_CLR_BOT = 3'd6,
    ACT_NONE    = 3'd7
  } cmp_act_e;

  localparam int CTL_RUN   = 4;
  localparam int CTL_OVFIE = 3;
  localparam int CTL_CLR   = 2;
  localparam int CH_IE     = 6;
  localparam int CH_EN     = 2;
  localparam logic [7:0] CH_MASK = 8'h7C;

endpackage

// File: rtl/tmr8_prescale.sv
`timescale 1ns/1ps
module tmr8_prescale #(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clr,
  input  logic [PW-1:0] div,
  output logic          tick
);
  localparam int CW = (2 ** PW) - 1;

  logic [CW-1:0] pre_q, pre_d;
  logic [CW-1:0] mask;

  always_comb begin
    mask = ~({CW{1'b1}} << div);
    tick = run && ((pre_q & mask) == mask);
    if (clr || !run) pre_d = '0;
    else             pre_d = pre_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R3
  stop_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pre_q == '0));

endmodule

// File: rtl/tmr8_counter.sv
`timescale 1ns/1ps
module tmr8_counter
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         clr,
  input  cnt_mode_e    mode,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt,
  output logic         going_down,
  output logic         step,
  output logic         wrap
);
  localparam logic [W-1:0] ALL1 = {W{1'b1}};
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         dn_q, dn_d;

  always_comb begin
    cnt_d = cnt_q;
    dn_d  = dn_q;
    wrap  = 1'b0;
    step  = tick && !clr;
    if (clr) begin
      cnt_d = '0;
      dn_d  = 1'b0;
    end else if (tick) begin
      unique case (mode)
        MODE_FREE: begin
          cnt_d = cnt_q + ONE;
          wrap  = (cnt_q == ALL1);
          dn_d  = 1'b0;
        end
        MODE_DOWN: begin
          dn_d = 1'b0;
          if (cnt_q == '0) begin
            cnt_d = top;
            wrap  = 1'b1;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
        MODE_MOD: begin
          dn_d = 1'b0;
          if (cnt_q == top) begin
            cnt_d = '0;
            wrap  = 1'b1;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
        default: begin
          if (!dn_q) begin
            if (cnt_q >= top) begin
              if (top != '0) begin
                cnt_d = cnt_q - ONE;
                dn_d  = 1'b1;
              end
            end else begin
              cnt_d = cnt_q + ONE;
            end
          end else if (cnt_q == '0) begin
            cnt_d = (top != '0) ? ONE : '0;
            dn_d  = 1'b0;
            wrap  = 1'b1;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dn_q  <= dn_d;
    end
  end

  assign cnt        = cnt_q;
  assign going_down = (mode == MODE_DOWN) || ((mode == MODE_UPDN) && dn_q);

  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt_q));

  // R7
  mod_climb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode == MODE_MOD && cnt_q < top) |=> (cnt_q == $past(cnt_q) + ONE));

  // R6
  down_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode == MODE_DOWN && cnt_q == '0) |=> (cnt_q == $past(top)));

endmodule

// File: rtl/tmr8_channel.sv
`timescale 1ns/1ps
module tmr8_channel
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] val,
  input  logic         going_down,
  input  logic         en,
  input  cmp_act_e     act,
  output logic         pin,
  output logic         hit
);
  logic pin_q, pin_d;
  logic at_top, at_bot;

  always_comb begin
    hit    = step && en && (cnt == val);
    at_top = step && en && (cnt == {W{1'b1}});
    at_bot = step && en && (cnt == '0);
    pin_d  = pin_q;
    unique case (act)
      ACT_SET:     if (hit) pin_d = 1'b1;
      ACT_CLR:     if (hit) pin_d = 1'b0;
      ACT_TGL:     if (hit) pin_d = ~pin_q;
      ACT_UP_SET:  if (hit) pin_d = ~going_down;
      ACT_UP_CLR:  if (hit) pin_d = going_down;
      ACT_SET_TOP: if (hit) pin_d = 1'b1; else if (at_top) pin_d = 1'b0;
      ACT_CLR_BOT: if (hit) pin_d = 1'b0; else if (at_bot) pin_d = 1'b1;
      default:     pin_d = pin_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  assign pin = pin_q;

  // R12
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(pin_q));

  // R9
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && act == ACT_TGL) |=> (pin_q != $past(pin_q)));

  // R10
  dir_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && act == ACT_UP_SET) |=> (pin_q == !$past(going_down)));

endmodule

// File: rtl/tmr8_top.sv
`timescale 1ns/1ps
module tmr8_top
  import tmr8_pkg::*;
#(
  parameter int W   = 8,
  parameter int NCH = 2,
  parameter int PW  = 3,
  parameter int AW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [7:0]     bus_wdata,
  output logic [7:0]     bus_rdata,
  output logic [NCH-1:0] cmp_out,
  output logic           irq
);
  localparam int FW = NCH + 1;
  localparam logic [AW-1:0] A_CTRL  = AW'(0);
  localparam logic [AW-1:0] A_CNT   = AW'(1);
  localparam logic [AW-1:0] A_FLAGS = AW'(2 + 2 * NCH);

  logic [1:0] rsync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  logic [7:0]    ctrl_q, ctrl_d;
  logic [7:0]    chctl_q [NCH];
  logic [7:0]    chctl_d [NCH];
  logic [W-1:0]  chval_q [NCH];
  logic [W-1:0]  chval_d [NCH];
  logic [FW-1:0] flags_q, flags_d;
  logic [NCH-1:0] hits;
  logic [FW-1:0] ie;

  logic         tick, step, wrap, going_down;
  logic [W-1:0] cnt;

  always_comb begin
    ctrl_d          = ctrl_q;
    ctrl_d[CTL_CLR] = 1'b0;
    if (bus_wr && bus_addr == A_CTRL) ctrl_d = bus_wdata;
    for (int i = 0; i < NCH; i++) begin
      chctl_d[i] = chctl_q[i];
      chval_d[i] = chval_q[i];
      if (bus_wr && bus_addr == AW'(2 + 2 * i)) chctl_d[i] = bus_wdata & CH_MASK;
      if (bus_wr && bus_addr == AW'(3 + 2 * i)) chval_d[i] = bus_wdata[W-1:0];
    end
    flags_d = flags_q;
    if (bus_wr && bus_addr == A_FLAGS) flags_d = flags_q & bus_wdata[FW-1:0];
    flags_d = flags_d | {hits, wrap};
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ctrl_q  <= '0;
      flags_q <= '0;
      for (int i = 0; i < NCH; i++) begin
        chctl_q[i] <= '0;
        chval_q[i] <= '0;
      end
    end else begin
      ctrl_q  <= ctrl_d;
      flags_q <= flags_d;
      for (int i = 0; i < NCH; i++) begin
        chctl_q[i] <= chctl_d[i];
        chval_q[i] <= chval_d[i];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL)  bus_rdata = ctrl_q;
    if (bus_addr == A_CNT)   bus_rdata = 8'(cnt);
    if (bus_addr == A_FLAGS) bus_rdata = 8'(flags_q);
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == AW'(2 + 2 * i)) bus_rdata = chctl_q[i];
      if (bus_addr == AW'(3 + 2 * i)) bus_rdata = 8'(chval_q[i]);
    end
  end

  always_comb begin
    ie[0] = ctrl_q[CTL_OVFIE];
    for (int i = 0; i < NCH; i++) ie[i+1] = chctl_q[i][CH_IE];
  end
  assign irq = |(flags_q & ie);

  tmr8_prescale #(.PW(PW)) u_pre (
    .clk  (clk),
    .rst_n(rst_i),
    .run  (ctrl_q[CTL_RUN]),
    .clr  (ctrl_q[CTL_CLR]),
    .div  (ctrl_q[7:8-PW]),
    .tick (tick)
  );

  tmr8_counter #(.W(W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_i),
    .tick      (tick),
    .clr       (ctrl_q[CTL_CLR]),
    .mode      (cnt_mode_e'(ctrl_q[1:0])),
    .top       (chval_q[0]),
    .cnt       (cnt),
    .going_down(going_down),
    .step      (step),
    .wrap      (wrap)
  );

  for (genvar g = 0; g < NCH; g++) begin : gen_ch
    tmr8_channel #(.W(W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_i),
      .step      (step),
      .cnt       (cnt),
      .val       (chval_q[g]),
      .going_down(going_down),
      .en        (chctl_q[g][CH_EN]),
      .act       (cmp_act_e'(chctl_q[g][5:3])),
      .pin       (cmp_out[g]),
      .hit       (hits[g])
    );
  end

  // R13
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (flags_q[0] && !(bus_wr && bus_addr == A_FLAGS)) |=> flags_q[0]);

  // R4
  clear_self_drop_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (ctrl_q[CTL_CLR] && !(bus_wr && bus_addr == A_CTRL)) |=> !ctrl_q[CTL_CLR]);

  // R13
  flag_write_zero_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (bus_wr && bus_addr == A_FLAGS && bus_wdata[0] == 1'b0 && !wrap) |=> !flags_q[0]);

endmodule

// File: tb/test_tmr8_top.sv
`timescale 1ns/1ps
module test_tmr8_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [1:0] cmp_out;
  logic       irq;

  int n_chk  = 0;
  int n_fail = 0;

  localparam logic [2:0] A_CTRL = 3'd0, A_CNT = 3'd1, A_C0CTL = 3'd2, A_C0VAL = 3'd3,
                         A_C1CTL = 3'd4, A_C1VAL = 3'd5, A_FLAGS = 3'd6;

  always #2.5 clk = ~clk;

  tmr8_top i_tmr8_top (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_out(cmp_out), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic pin_chk(input string tag, input logic exp);
    chk(tag, {7'd0, cmp_out[1]}, {7'd0, exp});
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic step(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic do_reset(input bit check);
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    step(3);
    if (check) begin
      for (int a = 0; a < 7; a++) rd_chk("R1 reg during reset", 3'(a), 8'h00);
      chk("R1 pins during reset", {6'd0, cmp_out}, 8'h00);
    end
    rst_n = 1'b1;
    step(3);
  endtask

  task automatic t_reset();
    do_reset(1'b1);
    for (int a = 0; a < 7; a++) rd_chk("R1 reg after reset", 3'(a), 8'h00);
    chk("R1 irq after reset", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_prescale();
    do_reset(1'b0);
    wr(A_CTRL, 8'h70);
    step(7);   rd_chk("R2 div8 before first move", A_CNT, 8'd0);
    step(1);   rd_chk("R2 div8 first move", A_CNT, 8'd1);
    step(16);  rd_chk("R2 div8 third move", A_CNT, 8'd3);
    do_reset(1'b0);
    wr(A_CTRL, 8'hF0);
    step(127); rd_chk("R2 div128 before move", A_CNT, 8'd0);
    step(1);   rd_chk("R2 div128 first move", A_CNT, 8'd1);
    step(128); rd_chk("R2 div128 second move", A_CNT, 8'd2);
  endtask

  task automatic t_runstop();
    do_reset(1'b0);
    wr(A_CTRL, 8'h10);
    step(5);  rd_chk("R3 running div1", A_CNT, 8'd5);
    wr(A_CTRL, 8'h00);
    rd_chk("R3 last move at stop write", A_CNT, 8'd6);
    step(10); rd_chk("R3 frozen", A_CNT, 8'd6);
    wr(A_CTRL, 8'h10);
    step(2);  rd_chk("R3 resumed from held value", A_CNT, 8'd8);
  endtask

  task automatic t_clear();
    do_reset(1'b0);
    wr(A_CTRL, 8'h10);
    step(9);  rd_chk("R4 pre-clear count", A_CNT, 8'd9);
    wr(A_CTRL, 8'h14);
    rd_chk("R4 clear bit latched", A_CTRL, 8'h14);
    step(1);  rd_chk("R4 count cleared", A_CNT, 8'd0);
    rd_chk("R4 clear bit self-drops", A_CTRL, 8'h10);
    step(3);  rd_chk("R4 counting after clear", A_CNT, 8'd3);
  endtask

  task automatic t_free();
    do_reset(1'b0);
    wr(A_CTRL, 8'h18);
    step(255); rd_chk("R5 count at 0xFF", A_CNT, 8'hFF);
    rd_chk("R5 no flag before roll", A_FLAGS, 8'h00);
    step(1);   rd_chk("R5 rolled to 0", A_CNT, 8'h00);
    rd_chk("R5 wrap flag", A_FLAGS, 8'h01);
    chk("R13 irq from wrap flag", {7'd0, irq}, 8'h01);
    wr(A_FLAGS, 8'h00);
    rd_chk("R13 flag cleared by zero write", A_FLAGS, 8'h00);
    chk("R13 irq dropped", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_down();
    do_reset(1'b0);
    wr(A_C0VAL, 8'd5);
    wr(A_CTRL, 8'h11);
    step(1); rd_chk("R6 reload from zero", A_CNT, 8'd5);
    rd_chk("R6 wrap flag on reload", A_FLAGS, 8'h01);
    step(5); rd_chk("R6 counted down to 0", A_CNT, 8'd0);
    step(1); rd_chk("R6 reload again", A_CNT, 8'd5);
  endtask

  task automatic t_modulo();
    do_reset(1'b0);
    wr(A_C0VAL, 8'd3);
    wr(A_CTRL, 8'h12);
    step(3); rd_chk("R7 at ceiling", A_CNT, 8'd3);
    rd_chk("R7 no flag yet", A_FLAGS, 8'h00);
    step(1); rd_chk("R7 wrapped", A_CNT, 8'd0);
    rd_chk("R7 wrap flag", A_FLAGS, 8'h01);
    step(3); rd_chk("R7 second period", A_CNT, 8'd3);
  endtask

  task automatic t_updown();
    logic [7:0] seq [8] = '{8'd1, 8'd2, 8'd3, 8'd2, 8'd1, 8'd0, 8'd1, 8'd2};
    do_reset(1'b0);
    wr(A_C0VAL, 8'd3);
    wr(A_CTRL, 8'h13);
    for (int k = 0; k < 8; k++) begin
      step(1);
      rd_chk("R8 up/down sequence", A_CNT, seq[k]);
      if (k == 5) rd_chk("R8 no flag at bottom yet", A_FLAGS, 8'h00);
      if (k == 6) rd_chk("R8 flag on leaving bottom", A_FLAGS, 8'h01);
    end
  endtask

  task automatic t_basic_actions();
    do_reset(1'b0);
    wr(A_C1VAL, 8'd4);
    wr(A_C1CTL, 8'h04);
    wr(A_CTRL, 8'h10);
    step(4); pin_chk("R9 set not yet", 1'b0);
    step(1); pin_chk("R9 set on match", 1'b1);
    rd_chk("R9 match flag", A_FLAGS, 8'h04);
    do_reset(1'b0);
    wr(A_C0VAL, 8'd3);
    wr(A_C1VAL, 8'd2);
    wr(A_C1CTL, 8'h14);
    wr(A_CTRL, 8'h12);
    step(3); pin_chk("R9 toggle first", 1'b1);
    step(3); pin_chk("R9 toggle holds between", 1'b1);
    step(1); pin_chk("R9 toggle second", 1'b0);
    do_reset(1'b0);
    wr(A_C0VAL, 8'd3);
    wr(A_C1VAL, 8'd1);
    wr(A_C1CTL, 8'h04);
    wr(A_CTRL, 8'h12);
    step(2); pin_chk("R9 set before clear test", 1'b1);
    wr(A_C1CTL, 8'h0C);
    step(2); pin_chk("R9 clear waits for match", 1'b1);
    step(1); pin_chk("R9 clear on match", 1'b0);
  endtask

  task automatic t_dir_actions();
    do_reset(1'b0);
    wr(A_C0VAL, 8'd4);
    wr(A_C1VAL, 8'd2);
    wr(A_C1CTL, 8'h1C);
    wr(A_CTRL, 8'h13);
    step(3); pin_chk("R10 act3 high on rising match", 1'b1);
    step(3); pin_chk("R10 act3 holds", 1'b1);
    step(1); pin_chk("R10 act3 low on falling match", 1'b0);
    step(4); pin_chk("R10 act3 high again", 1'b1);
    do_reset(1'b0);
    wr(A_C0VAL, 8'd4);
    wr(A_C1VAL, 8'd2);
    wr(A_C1CTL, 8'h24);
    wr(A_CTRL, 8'h13);
    step(7); pin_chk("R10 act4 high on falling match", 1'b1);
    step(4); pin_chk("R10 act4 low on rising match", 1'b0);
  endtask

  task automatic t_edge_actions();
    do_reset(1'b0);
    wr(A_C1VAL, 8'h10);
    wr(A_C1CTL, 8'h2C);
    wr(A_CTRL, 8'h10);
    step(16);  pin_chk("R11 act5 before match", 1'b0);
    step(1);   pin_chk("R11 act5 set on match", 1'b1);
    step(238); pin_chk("R11 act5 holds to 0xFF", 1'b1);
    step(1);   pin_chk("R11 act5 cleared leaving 0xFF", 1'b0);
    do_reset(1'b0);
    wr(A_C1VAL, 8'h10);
    wr(A_C1CTL, 8'h34);
    wr(A_CTRL, 8'h10);
    step(1);  pin_chk("R11 act6 set leaving 0x00", 1'b1);
    step(15); pin_chk("R11 act6 holds", 1'b1);
    step(1);  pin_chk("R11 act6 cleared on match", 1'b0);
  endtask

  task automatic t_disable();
    do_reset(1'b0);
    wr(A_C1VAL, 8'd2);
    wr(A_C1CTL, 8'h00);
    wr(A_CTRL, 8'h10);
    step(5);
    pin_chk("R12 pin untouched when disabled", 1'b0);
    rd_chk("R12 no flag when disabled", A_FLAGS, 8'h00);
  endtask

  task automatic t_flags();
    do_reset(1'b0);
    wr(A_C1VAL, 8'd2);
    wr(A_C1CTL, 8'h04);
    wr(A_CTRL, 8'h10);
    step(3);  rd_chk("R13 match flag set", A_FLAGS, 8'h04);
    chk("R13 irq gated off", {7'd0, irq}, 8'h00);
    step(10); rd_chk("R13 flag sticky", A_FLAGS, 8'h04);
    wr(A_C1CTL, 8'h44);
    chk("R13 irq with enable", {7'd0, irq}, 8'h01);
    wr(A_FLAGS, 8'hFB);
    rd_chk("R13 zero bit cleared", A_FLAGS, 8'h00);
    chk("R13 irq cleared", {7'd0, irq}, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    @(negedge clk);
    t_reset();
    t_prescale();
    t_runstop();
    t_clear();
    t_free();
    t_down();
    t_modulo();
    t_updown();
    t_basic_actions();
    t_dir_actions();
    t_edge_actions();
    t_disable();
    t_flags();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule